// File: doc/BRIEF.md
# Sub-Block Valid Read Cache

This block is a direct-mapped read cache placed between a processor load port and a slower backing memory. Each cache line stores a single address tag, but its data is divided into several sub-blocks, and each sub-block carries its own valid flag. As a result, a line can be partly filled under one tag. A lookup succeeds only when the stored tag matches and the requested sub-block is marked valid.

On a miss, the cache sends the backing memory a request for exactly one sub-block, which is the one being read. While that request is outstanding, the processor port is held off. When the memory answers, the cache returns the word to the processor and writes it into the line. If the line held a different tag, it takes the new tag and discards all of its other sub-blocks. If the tag already matched, the other sub-blocks are kept.

The processor address is divided into four fields. From most to least significant they are: tag, line index, sub-block select and byte offset. The width of each field is a parameter.

Top module: `sector_cache`

## Requirements
- R1: After a synchronous active-low reset, every sub-block of every line is invalid. `req_ready` is 1, while `resp_valid` and `mem_req_valid` are 0. The first read of any address is therefore a miss.
- R2: A read whose tag matches and whose sub-block is valid is a hit. It raises `resp_valid` in the cycle after acceptance, returns the stored word, and issues no memory request.
- R3: A read whose tag matches but whose sub-block valid flag is clear is treated as a miss.
- R4: A miss raises `mem_req_valid` for exactly one cycle, in the cycle after acceptance. `mem_req_addr` equals the request address with its byte-offset bits removed, which is {tag, index, sub-block}. Only that one sub-block is requested.
- R5: `req_ready` is 0 from the cycle after a miss is accepted until the response cycle. Only one miss is outstanding at a time.
- R6: The cycle after `mem_resp_valid` is seen for an outstanding miss, `resp_valid` is 1 and `resp_data` equals `mem_resp_data`.
- R7: A fill under a tag that already matches sets the filled sub-block valid and keeps the others. A line of four sub-blocks can therefore hold patterns such as 0101, 1100 and 1111, where bit i is sub-block i.
- R8: A fill under a different tag writes the new tag and leaves only the filled sub-block valid. Reads of the old tag then miss.
- R9: The byte-offset bits take no part in the lookup. Addresses that differ only in those bits map to the same sub-block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor read request |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | ADDR_W | Byte address: {tag, index, sub-block, offset} |
| resp_valid | output | 1 | Read data valid |
| resp_data | output | DATA_W | Read data |
| mem_req_valid | output | 1 | One-cycle sub-block fetch request |
| mem_req_addr | output | ADDR_W-OFF_W | Sub-block address {tag, index, sub-block} |
| mem_resp_valid | input | 1 | Memory returns the requested sub-block |
| mem_resp_data | input | DATA_W | Returned sub-block word |

## Verification
Some properties are checked by assertions on every cycle. A miss must raise a single fetch pulse with the latched address and must drop `req_ready`. A hit must answer in the following cycle. A fill must return the memory word. The line's valid flags must follow the keep-or-clear rule, depending on whether the tag matched.

Other behaviour can only be shown through the bench's scenarios against its reference model. These include:
- the actual valid patterns built up across several fills, such as 0101, 1100 and 1111;
- old-tag reads missing after a retag;
- byte offsets being ignored;
- correct data coming back after conflicts between lines.

// File: rtl/sector_cache_pkg.sv
// Shared types for the sub-block valid read cache.
package sector_cache_pkg;
    // Miss-handling states: idle/hit service, fetch issue, wait for data.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } ctrl_state_e;
endpackage

// File: rtl/sector_tag_store.sv
// Tag and per-sub-block valid array of the direct-mapped cache.
// Purpose: combinational lookup for the current request, and tag/valid update on fill.
// Assumes: at most one fill per cycle; tags are not reset, only valids are.
module sector_tag_store #(
    parameter int TAG_W = 9,
    parameter int IDX_W = 3,
    parameter int SUB_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic [SUB_W-1:0] lk_sub,
    output logic             lk_hit,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [SUB_W-1:0] fill_sub
);
    localparam int LINES = 1 << IDX_W;
    localparam int SUBS  = 1 << SUB_W;

    logic [TAG_W-1:0] tag_q   [LINES];
    logic [SUBS-1:0]  valid_q [LINES];
    logic             retag;
    logic [SUBS-1:0]  fill_mask;

    // A fill replaces the line's tag when the line is empty or holds another tag.
    assign retag     = (valid_q[fill_idx] == '0) || (tag_q[fill_idx] != fill_tag);
    assign fill_mask = SUBS'(1) << fill_sub;

    // Hit requires both a tag match and the addressed sub-block being valid.
    assign lk_hit = valid_q[lk_idx][lk_sub] && (tag_q[lk_idx] == lk_tag);

    // Tag write on retag.
    always_ff @(posedge clk) begin
        if (fill_en && retag) begin
            tag_q[fill_idx] <= fill_tag;
        end
    end

    // Per-line valid flags: cleared at reset, cleared or kept on fill, then fill bit set.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= '0;
            end else if (fill_en && (fill_idx == IDX_W'(g))) begin
                valid_q[g] <= (retag ? '0 : valid_q[g]) | fill_mask;
            end
        end
    end

    AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> valid_q[$past(fill_idx)][$past(fill_sub)]); // R7
    AST_FILL_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !retag) |=>
        ((valid_q[$past(fill_idx)] & $past(valid_q[fill_idx])) == $past(valid_q[fill_idx]))); // R7
    AST_RETAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && retag) |=> ($countones(valid_q[$past(fill_idx)]) == 1)); // R8
endmodule

// File: rtl/sector_data_store.sv
// Data array holding one word per sub-block of every line.
// Purpose: asynchronous read at the lookup address, synchronous write on fill.
// Assumes: caller registers the read result; contents are undefined until filled.
module sector_data_store #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int SUB_W  = 2
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  logic [IDX_W+SUB_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [IDX_W+SUB_W-1:0] rd_addr,
    output logic [DATA_W-1:0]      rd_data
);
    localparam int ENTRIES = 1 << (IDX_W + SUB_W);

    logic [DATA_W-1:0] mem_q [ENTRIES];

    // Write the refilled sub-block word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Read the addressed sub-block word.
    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/sector_ctrl.sv
// Miss controller: accepts requests, issues one sub-block fetch per miss, waits for data.
// Purpose: sequence IDLE -> ISSUE -> WAIT -> IDLE for a miss; hits stay in IDLE.
// Assumes: memory accepts the one-cycle request unconditionally and answers once.
module sector_ctrl #(
    parameter int BLK_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [BLK_W-1:0] req_blk,
    input  logic             lk_hit,
    output logic             req_ready,
    output logic             hit_fire,
    output logic             mem_req_valid,
    output logic [BLK_W-1:0] mem_req_blk,
    input  logic             mem_resp_valid,
    output logic             fill_en
);
    import sector_cache_pkg::*;

    ctrl_state_e      state_q;
    logic [BLK_W-1:0] blk_q;
    logic             accept;

    assign req_ready     = (state_q == ST_IDLE);
    assign accept        = req_valid && req_ready;
    assign hit_fire      = accept && lk_hit;
    assign mem_req_valid = (state_q == ST_ISSUE);
    assign mem_req_blk   = blk_q;
    assign fill_en       = (state_q == ST_WAIT) && mem_resp_valid;

    // State sequencing for one outstanding miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (accept && !lk_hit) state_q <= ST_ISSUE;
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT:  if (mem_resp_valid) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Latch the missing sub-block address at acceptance.
    always_ff @(posedge clk) begin
        if (accept && !lk_hit) begin
            blk_q <= req_blk;
        end
    end

    AST_MISS_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !lk_hit) |=> mem_req_valid); // R4
    AST_SINGLE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid); // R4
    AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_blk == $past(req_blk))); // R4
    AST_STALL_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !lk_hit) |=> !req_ready); // R5
endmodule

// File: rtl/sector_cache.sv
// Direct-mapped read cache with one tag per line and a valid flag per sub-block.
// Purpose: serve hits in one cycle; fetch only the missing sub-block on a miss.
// Assumes: address layout {tag, index, sub-block, byte offset}; one miss at a time.
module sector_cache #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2,
    parameter int SUB_W  = 2,
    parameter int IDX_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    output logic                    resp_valid,
    output logic [DATA_W-1:0]       resp_data,
    output logic                    mem_req_valid,
    output logic [ADDR_W-OFF_W-1:0] mem_req_addr,
    input  logic                    mem_resp_valid,
    input  logic [DATA_W-1:0]       mem_resp_data
);
    localparam int BLK_W = ADDR_W - OFF_W;
    localparam int TAG_W = ADDR_W - IDX_W - SUB_W - OFF_W;
    localparam int LOC_W = IDX_W + SUB_W;

    logic [BLK_W-1:0]  req_blk;
    logic              lk_hit;
    logic              hit_fire;
    logic              fill_en;
    logic [DATA_W-1:0] rd_data;
    logic              resp_valid_q;
    logic [DATA_W-1:0] resp_data_q;

    assign req_blk = req_addr[ADDR_W-1:OFF_W];

    sector_ctrl #(.BLK_W(BLK_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_blk       (req_blk),
        .lk_hit        (lk_hit),
        .req_ready     (req_ready),
        .hit_fire      (hit_fire),
        .mem_req_valid (mem_req_valid),
        .mem_req_blk   (mem_req_addr),
        .mem_resp_valid(mem_resp_valid),
        .fill_en       (fill_en)
    );

    sector_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .SUB_W(SUB_W)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_idx  (req_blk[LOC_W-1:SUB_W]),
        .lk_tag  (req_blk[BLK_W-1:LOC_W]),
        .lk_sub  (req_blk[SUB_W-1:0]),
        .lk_hit  (lk_hit),
        .fill_en (fill_en),
        .fill_idx(mem_req_addr[LOC_W-1:SUB_W]),
        .fill_tag(mem_req_addr[BLK_W-1:LOC_W]),
        .fill_sub(mem_req_addr[SUB_W-1:0])
    );

    sector_data_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SUB_W(SUB_W)) u_data (
        .clk    (clk),
        .wr_en  (fill_en),
        .wr_addr(mem_req_addr[LOC_W-1:0]),
        .wr_data(mem_resp_data),
        .rd_addr(req_blk[LOC_W-1:0]),
        .rd_data(rd_data)
    );

    // Response valid: one cycle after a hit or after the refill word arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_q <= 1'b0;
        end else begin
            resp_valid_q <= hit_fire || fill_en;
        end
    end

    // Response data: refill word forwarded on a fill, stored word on a hit.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            resp_data_q <= mem_resp_data;
        end else if (hit_fire) begin
            resp_data_q <= rd_data;
        end
    end

    assign resp_valid = resp_valid_q;
    assign resp_data  = resp_data_q;

    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_fire |=> (resp_valid && !mem_req_valid)); // R2
    AST_FILL_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (resp_valid && (resp_data == $past(mem_resp_data)))); // R6
endmodule

// File: tb/sector_cache_test.sv
module sector_cache_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16, DATA_W = 32, OFF_W = 2, SUB_W = 2, IDX_W = 3;
    localparam int BLK_W = ADDR_W - OFF_W;
    localparam int LINES = 1 << IDX_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, mem_resp_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] mem_resp_data = '0;
    logic req_ready, resp_valid, mem_req_valid;
    logic [DATA_W-1:0] resp_data;
    logic [BLK_W-1:0] mem_req_addr;

    int checks = 0, failures = 0;
    bit done = 0;

    // Reference model: tag per line, valid nibble per line.
    int       ref_tag [LINES];
    bit [3:0] ref_v   [LINES];

    sector_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W),
                   .SUB_W(SUB_W), .IDX_W(IDX_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .resp_valid(resp_valid), .resp_data(resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DATA_W-1:0] mem_word(int blk);
        return (DATA_W'(blk) * 32'h9E3779B1) ^ 32'h13579BDF;
    endfunction

    function automatic logic [ADDR_W-1:0] mk(int tag, int idx, int sub, int off);
        return {9'(tag), 3'(idx), 2'(sub), 2'(off)};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One read, starting at a negedge; model decides hit or miss.
    task automatic rd(int tag, int idx, int sub, int off, int lat, string req);
        logic [ADDR_W-1:0] a = mk(tag, idx, sub, off);
        int blk = int'(a[ADDR_W-1:OFF_W]);
        bit hit = ref_v[idx][sub] && (ref_tag[idx] == tag);
        chk(req_ready == 1'b1, {req, " ready before request (R5)"}, 32'(req_ready), 1);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (hit) begin
            chk(resp_valid && !mem_req_valid, {req, " hit responds next cycle (R2)"},
                {30'd0, resp_valid, mem_req_valid}, 32'd2);
            chk(resp_data == mem_word(blk), {req, " hit data (R2)"}, resp_data, mem_word(blk));
        end else begin
            chk(!resp_valid && mem_req_valid, {req, " miss issues fetch (R4)"},
                {30'd0, resp_valid, mem_req_valid}, 32'd1);
            chk(mem_req_addr == BLK_W'(blk), {req, " fetch address (R4)"},
                32'(mem_req_addr), 32'(blk));
            chk(req_ready == 1'b0, {req, " stall during miss (R5)"}, 32'(req_ready), 0);
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                chk(!mem_req_valid && !req_ready && !resp_valid,
                    {req, " single fetch, still stalled (R4 R5)"},
                    {29'd0, mem_req_valid, req_ready, resp_valid}, 0);
            end
            mem_resp_valid = 1'b1; mem_resp_data = mem_word(blk);
            @(negedge clk);
            mem_resp_valid = 1'b0; mem_resp_data = '0;
            chk(resp_valid == 1'b1, {req, " fill response valid (R6)"}, 32'(resp_valid), 1);
            chk(resp_data == mem_word(blk), {req, " fill data (R6)"}, resp_data, mem_word(blk));
            if (ref_v[idx] == 4'b0 || ref_tag[idx] != tag) begin
                ref_tag[idx] = tag; ref_v[idx] = 4'b0;
            end
            ref_v[idx][sub] = 1'b1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin ref_tag[i] = 0; ref_v[i] = 4'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(req_ready && !resp_valid && !mem_req_valid, "R1 reset outputs",
            {29'd0, req_ready, resp_valid, mem_req_valid}, 32'd4);
        rd(5, 0, 0, 0, 2, "R1 first read misses");
        // R3: tag matches, sub-block 2 invalid
        rd(5, 0, 2, 1, 1, "R3 tag match invalid sub");
        // R9: offset ignored
        rd(5, 0, 0, 3, 1, "R9 offset 3 hits");
        rd(5, 0, 2, 0, 1, "R7 pattern 0101 hit");
        rd(5, 0, 1, 0, 3, "R3 fill sub1");
        rd(5, 0, 3, 2, 1, "R7 fill sub3 to 1111");
        for (int s = 0; s < 4; s++) rd(5, 0, s, s, 1, "R7 pattern 1111 hits");
        // R7: pattern 1100 on line 1
        rd(9, 1, 2, 0, 4, "R7 line1 sub2");
        rd(9, 1, 3, 0, 1, "R7 line1 sub3");
        rd(9, 1, 3, 1, 1, "R7 pattern 1100 hit");
        rd(9, 1, 0, 0, 1, "R3 line1 sub0 miss");
        // R8: retag line 0
        rd(6, 0, 1, 0, 2, "R8 retag");
        rd(6, 0, 0, 0, 1, "R8 others cleared");
        rd(5, 0, 1, 0, 1, "R8 old tag misses");
        rd(5, 0, 2, 0, 1, "R8 old tag sub2 misses");
        rd(9, 1, 2, 2, 1, "R7 other line unaffected");
        // Strided conflicts and back-to-back hits across lines
        for (int t = 0; t < 3; t++)
            for (int l = 0; l < LINES; l++)
                rd(t + 20, l, l % 4, 0, (l % 3) + 1, "R8 stride conflict");
        for (int l = 0; l < LINES; l++) rd(22, l, l % 4, 2, 1, "R2 back-to-back hits");
        @(negedge clk);
        chk(!resp_valid && !mem_req_valid, "R2 idle after last hit",
            {30'd0, resp_valid, mem_req_valid}, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule